// File: doc/BRIEF.md
# Multi-rate I2C base clock generator

This block turns one peripheral bus clock into four independent tick streams. Each stream is a one-cycle enable strobe in the bus clock domain, not a derived clock. Three streams act as timing bases for the Fast-mode Plus, Fast and Standard bus speeds. The fourth stream paces an auto-recovery timeout counter. All four ratios come from one 32-bit divider register that holds four 8-bit fields. A field programs a ratio of (field >> 1) + 1, so its lowest bit carries no weight. No stream runs until a control bit enables the divider mode.

The block also contains a bus-free interval timer. A start pulse captures a 2-bit speed code. The timer then counts sixteen ticks of the chosen base. After the sixteenth tick it raises a done flag, which stays high until the next start pulse.

The timer is a three-state machine. From IDLE it goes to COUNT on start. COUNT re-enters itself on start (RESTART) and moves to DONE on the sixteenth selected tick (EXPIRE). From DONE it goes back to COUNT on start (REARM). Reset returns it to IDLE.

Top module: `i2c_baseclk_gen`

## Requirements
- R1: After synchronous reset, the divider register holds 0x62220803 and the mode bit is clear. No tick fires and the done flag is low. Once the mode is enabled, the periods follow that value: 2, 5, 18 and 50 cycles.
- R2: While the mode bit is clear, no tick output is ever asserted, whatever the divider fields hold.
- R3: Divider bits [7:0] set the Fast-mode Plus tick, [15:8] the Fast-mode tick, [23:16] the Standard tick and [31:24] the recovery tick. Each tick repeats every (field >> 1) + 1 cycles as a one-cycle strobe.
- R4: The lowest bit of each field is ignored. For example, 0x09 gives the same period as 0x08.
- R5: A field of 0 or 1 gives a ratio of 1. Its tick is then high on every cycle while the mode is enabled.
- R6: Any register write restarts all four counters from phase zero. The first tick of a base with ratio N appears in the Nth cycle after the write cycle.
- R7: A start pulse begins a count of selected-base ticks seen in the cycles after the start cycle. Done rises in the cycle after the sixteenth such tick. Speed code 0 selects Standard, 1 Fast, 2 Fast-mode Plus and 3 recovery.
- R8: Done stays high until a start pulse arrives. In the cycle after that pulse, done is low.
- R9: A start pulse during a count discards the ticks counted so far and begins again from zero.
- R10: The speed code is captured only in the start cycle. Changes to it during a count have no effect.
- R11: A write with wr_sel = 0 targets the control register, where bit 0 enables the divider mode. A write with wr_sel = 1 loads the whole divider register. A control write leaves the divider fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divider |
| wr_data | input | 32 | Write data |
| speed_sel | input | 2 | Bus-free timer speed code |
| tbuf_start | input | 1 | Bus-free timer start pulse |
| tick_fmp | output | 1 | Fast-mode Plus base tick |
| tick_fm | output | 1 | Fast-mode base tick |
| tick_std | output | 1 | Standard-mode base tick |
| tick_rec | output | 1 | Auto-recovery base tick |
| tbuf_done | output | 1 | Bus-free interval elapsed |

## Verification
A counter left with a wrong phase or a stale ratio shows at a tick port within one period of that base after a write. The first tick then arrives early or late relative to the Nth cycle after the write. A field bit wired to the wrong lane shows as a wrong period on some other port. If the timer machine is stuck or miscounts, done rises one or more selected ticks early or late, or fails to drop in the cycle after a start. So every timer fault shows within about sixteen periods of the chosen base.

// File: rtl/i2c_bclk_pkg.sv
package i2c_bclk_pkg;

    localparam int NUM_BASE = 4;

    // Lane index of each base inside the divider register and tick vector
    localparam int LANE_FMP = 0;
    localparam int LANE_FM  = 1;
    localparam int LANE_STD = 2;
    localparam int LANE_REC = 3;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_FMP  = 2'd2,
        SPD_REC  = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        TB_IDLE  = 2'd0,
        TB_COUNT = 2'd1,
        TB_DONE  = 2'd2
    } tbuf_state_e;

    function automatic logic [1:0] speed_to_lane(input logic [1:0] code);
        logic [1:0] lane;
        unique case (speed_e'(code))
            SPD_STD:  lane = 2'(LANE_STD);
            SPD_FAST: lane = 2'(LANE_FM);
            SPD_FMP:  lane = 2'(LANE_FMP);
            SPD_REC:  lane = 2'(LANE_REC);
            default:  lane = 2'(LANE_STD);
        endcase
        return lane;
    endfunction

endpackage

// File: rtl/i2c_bclk_regs.sv
module i2c_bclk_regs #(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] RESET_DIV = 32'h6222_0803
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mode_en,
    output logic [DATA_W-1:0] div_q,
    output logic              restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en <= 1'b0;
            div_q   <= DATA_W'(RESET_DIV);
        end else if (wr_en) begin
            if (wr_sel) begin
                div_q <= wr_data;
            end else begin
                mode_en <= wr_data[0];
            end
        end
    end

    // Every write, to either register, realigns all counters
    assign restart = wr_en;

endmodule

// File: rtl/i2c_bclk_div.sv
module i2c_bclk_div #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               restart,
    input  logic [FIELD_W-1:0] field,
    output logic               tick
);

    localparam int CNT_W = FIELD_W - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             hit;

    // The ratio is half the field plus one: the LSB drops out here
    assign last = field[FIELD_W-1:1];
    assign hit  = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = enable && hit;

endmodule

// File: rtl/i2c_bclk_tbuf.sv
module i2c_bclk_tbuf
    import i2c_bclk_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int TBUF_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       speed_sel,
    input  logic [LANES-1:0] ticks,
    output logic             done,
    output logic [1:0]       lane_q
);

    localparam int CNT_W = $clog2(TBUF_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TBUF_TICKS - 1);

    tbuf_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             sel_tick;

    assign sel_tick = ticks[lane_q];

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Tick counter and captured lane
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lane_q <= 2'(LANE_STD);
        end else if (start) begin
            cnt    <= '0;
            lane_q <= speed_to_lane(speed_sel);
        end else if (state == TB_COUNT && sel_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Transitions: START, RESTART, EXPIRE, REARM
    always_comb begin
        state_nx = state;
        unique case (state)
            TB_IDLE: begin
                if (start) state_nx = TB_COUNT;
            end
            TB_COUNT: begin
                if (start) begin
                    state_nx = TB_COUNT;
                end else if (sel_tick && cnt == LAST) begin
                    state_nx = TB_DONE;
                end
            end
            TB_DONE: begin
                if (start) state_nx = TB_COUNT;
            end
            default: state_nx = TB_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done = 1'b0;
        unique case (state)
            TB_IDLE:  done = 1'b0;
            TB_COUNT: done = 1'b0;
            TB_DONE:  done = 1'b1;
            default:  done = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_baseclk_gen.sv
module i2c_baseclk_gen
    import i2c_bclk_pkg::*;
#(
    parameter int          FIELD_W    = 8,
    parameter int          TBUF_TICKS = 16,
    parameter logic [31:0] RESET_DIV  = 32'h6222_0803
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  speed_sel,
    input  logic        tbuf_start,
    output logic        tick_fmp,
    output logic        tick_fm,
    output logic        tick_std,
    output logic        tick_rec,
    output logic        tbuf_done
);

    localparam int DATA_W = FIELD_W * NUM_BASE;

    logic              mode_en;
    logic [DATA_W-1:0] div_q;
    logic              restart;
    logic [NUM_BASE-1:0] base_tick;
    logic [1:0]        tbuf_lane;

    i2c_bclk_regs #(
        .DATA_W   (DATA_W),
        .RESET_DIV(RESET_DIV)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data[DATA_W-1:0]),
        .mode_en(mode_en),
        .div_q  (div_q),
        .restart(restart)
    );

    for (genvar g = 0; g < NUM_BASE; g++) begin : g_lane
        i2c_bclk_div #(
            .FIELD_W(FIELD_W)
        ) u_div (
            .clk    (clk),
            .rst    (rst),
            .enable (mode_en),
            .restart(restart),
            .field  (div_q[g*FIELD_W +: FIELD_W]),
            .tick   (base_tick[g])
        );
    end

    i2c_bclk_tbuf #(
        .LANES     (NUM_BASE),
        .TBUF_TICKS(TBUF_TICKS)
    ) u_tbuf (
        .clk      (clk),
        .rst      (rst),
        .start    (tbuf_start),
        .speed_sel(speed_sel),
        .ticks    (base_tick),
        .done     (tbuf_done),
        .lane_q   (tbuf_lane)
    );

    assign tick_fmp = base_tick[LANE_FMP];
    assign tick_fm  = base_tick[LANE_FM];
    assign tick_std = base_tick[LANE_STD];
    assign tick_rec = base_tick[LANE_REC];

endmodule

// File: rtl/i2c_baseclk_chk.sv
module i2c_baseclk_chk #(
    parameter int FIELD_W = 8,
    parameter int LANES   = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic                     tbuf_start,
    input logic                     tbuf_done,
    input logic                     mode_en,
    input logic [FIELD_W*LANES-1:0] div_q,
    input logic [LANES-1:0]         ticks,
    input logic [1:0]               sel_q
);

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ticks == '0 && !tbuf_done))
        else $error("a_r1_reset_quiet");

    // R2: disabled mode never ticks
    a_r2_mode_off: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> (ticks == '0))
        else $error("a_r2_mode_off");

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // R3: a ratio above one never gives back-to-back strobes
        a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
            (ticks[i] && !wr_en && div_q[i*FIELD_W+1 +: FIELD_W-1] != '0)
            |=> !ticks[i])
            else $error("a_r3_spacing");

        // R5: ratio one with the mode on ticks every cycle
        a_r5_every_cycle: assert property (@(posedge clk) disable iff (rst)
            (mode_en && div_q[i*FIELD_W+1 +: FIELD_W-1] == '0) |-> ticks[i])
            else $error("a_r5_every_cycle");

        // R6: the cycle after a write starts from phase zero
        a_r6_restart: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> (!ticks[i] || div_q[i*FIELD_W+1 +: FIELD_W-1] == '0))
            else $error("a_r6_restart");
    end

    // R7: done rises only after a tick of the captured lane
    a_r7_done_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(tbuf_done) |-> $past(ticks[sel_q]))
        else $error("a_r7_done_after_tick");

    // R8: done holds until a start
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (tbuf_done && !tbuf_start) |=> tbuf_done)
        else $error("a_r8_done_hold");

    // R8: start drops done on the next cycle
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        tbuf_start |=> !tbuf_done)
        else $error("a_r8_start_clears");

endmodule

bind i2c_baseclk_gen i2c_baseclk_chk #(
    .FIELD_W(FIELD_W),
    .LANES  (i2c_bclk_pkg::NUM_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .tbuf_start(tbuf_start),
    .tbuf_done (tbuf_done),
    .mode_en   (mode_en),
    .div_q     (div_q),
    .ticks     (base_tick),
    .sel_q     (tbuf_lane)
);

// File: tb/sim_i2c_baseclk_gen.sv
module sim_i2c_baseclk_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  speed_sel = '0;
    logic        tbuf_start = 1'b0;
    logic        tick_fmp, tick_fm, tick_std, tick_rec, tbuf_done;

    i2c_baseclk_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .speed_sel (speed_sel),
        .tbuf_start(tbuf_start),
        .tick_fmp  (tick_fmp),
        .tick_fm   (tick_fm),
        .tick_std  (tick_std),
        .tick_rec  (tick_rec),
        .tbuf_done (tbuf_done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    // Bench model of the registers
    logic [31:0] div_m = 32'h6222_0803;
    logic        en_m  = 1'b0;

    // Scoreboard: expected tick cycles per lane (0 FMP, 1 FM, 2 STD, 3 REC)
    int exp_q [4][$];
    int watch_until [4] = '{-1, -1, -1, -1};

    logic [3:0] tvec;
    assign tvec = {tick_rec, tick_std, tick_fm, tick_fmp};

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected end before 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Monitor: pops expected ticks and compares against the ports
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                if (cyc <= watch_until[i]) begin
                    logic want;
                    want = (exp_q[i].size() > 0 && exp_q[i][0] == cyc);
                    if (want) void'(exp_q[i].pop_front());
                    checks++;
                    if (tvec[i] !== want) begin
                        errors++;
                        $display("FAIL %s lane %0d cycle %0d: actual tick %b expected %b",
                                 cur_req, i, cyc, tvec[i], want);
                    end
                end
            end
        end
    end

    function automatic int ratio(input logic [7:0] f);
        return int'(f >> 1) + 1;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Driver: performs a write, pushes expected ticks for a window of hold cycles
    task automatic write_reg(input logic sel, input logic [31:0] d, input int hold, input string req);
        int wcyc;
        step();
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        wcyc = cyc;
        if (sel) div_m = d; else en_m = d[0];
        cur_req = req;
        for (int i = 0; i < 4; i++) begin
            exp_q[i].delete();
            watch_until[i] = wcyc + hold;
            if (en_m) begin
                int n;
                n = ratio(div_m[i*8 +: 8]);
                for (int t = wcyc + n; t <= wcyc + hold; t += n) exp_q[i].push_back(t);
            end
        end
        step();
        wr_en = 1'b0;
        while (cyc <= wcyc + hold) step();
    endtask

    function automatic int spd_lane(input logic [1:0] s);
        case (s)
            2'd0: return 2;
            2'd1: return 1;
            2'd2: return 0;
            default: return 3;
        endcase
    endfunction

    // Bus-free run: counts selected ticks itself; returns cycles from start to done
    task automatic tbuf_run(input logic [1:0] spd, input int stop_after, input logic [1:0] chg,
                            input logic do_chg, input string req, output int span);
        int ln, n, scyc;
        ln = spd_lane(spd);
        step();
        tbuf_start = 1'b1; speed_sel = spd; scyc = cyc;
        step();
        tbuf_start = 1'b0;
        if (do_chg) speed_sel = chg;
        n = 0;
        span = 0;
        forever begin
            if (tbuf_done) begin
                check(req, tbuf_done, 1'b0, "done early");
                break;
            end
            if (tvec[ln]) n++;
            if (n == stop_after) break;
            step();
        end
        if (stop_after == 16) begin
            check(req, tbuf_done, 1'b0, "done before last tick edge");
            step();
            check(req, tbuf_done, 1'b1, "done after sixteenth tick");
            span = cyc - scyc;
        end
    endtask

    initial begin
        int span;
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1: reset state
        check("R1", tbuf_done, 1'b0, "done after reset");
        check("R1", |tvec, 1'b0, "ticks after reset");
        cur_req = "R1";
        for (int i = 0; i < 4; i++) watch_until[i] = cyc + 30;
        repeat (32) step();

        // R1 and R11: enabling through the control register keeps reset divider
        write_reg(1'b0, 32'h0000_0001, 160, "R1");

        // R3: lane mapping and periods
        write_reg(1'b1, 32'h1E14_0602, 140, "R3");

        // R4: odd fields behave as one lower
        write_reg(1'b1, 32'h0B0D_0907, 140, "R4");

        // R5: field 0 and 1 tick every cycle
        write_reg(1'b1, 32'h0100_0100, 20, "R5");

        // R6: rewrite mid-phase realigns counters
        write_reg(1'b1, 32'h1E14_0602, 7, "R6");
        write_reg(1'b1, 32'h1E14_0602, 100, "R6");

        // R2: mode off ignores fields, even after a divider write
        write_reg(1'b0, 32'h0000_0000, 60, "R2");
        write_reg(1'b1, 32'h0000_0000, 40, "R2");

        // R11: control write upper bits ignored, divider kept
        write_reg(1'b0, 32'hFFFF_FFFE, 30, "R11");
        write_reg(1'b0, 32'h0000_0001, 30, "R11");
        write_reg(1'b1, 32'h6222_0803, 120, "R11");

        // R7: each speed code, counted at the ports
        tbuf_run(2'd2, 16, 2'd0, 1'b0, "R7", span);
        tbuf_run(2'd0, 16, 2'd0, 1'b0, "R7", span);
        tbuf_run(2'd1, 16, 2'd0, 1'b0, "R7", span);
        tbuf_run(2'd3, 16, 2'd0, 1'b0, "R7", span);

        // R8: done holds, start drops it next cycle
        repeat (25) begin
            step();
            check("R8", tbuf_done, 1'b1, "done hold");
        end
        step();
        tbuf_start = 1'b1; speed_sel = 2'd0;
        step();
        tbuf_start = 1'b0;
        check("R8", tbuf_done, 1'b0, "done after start");

        // R9: restart mid-count counts anew
        tbuf_run(2'd0, 5, 2'd0, 1'b0, "R9", span);
        tbuf_run(2'd0, 16, 2'd0, 1'b0, "R9", span);

        // R10: speed change mid-count ignored
        tbuf_run(2'd1, 16, 2'd0, 1'b1, "R10", span);

        // R7 corner: ratio one gives done 17 cycles after start
        write_reg(1'b1, 32'h6222_0800, 4, "R5");
        tbuf_run(2'd2, 16, 2'd0, 1'b0, "R7", span);
        checks++;
        if (span != 17) begin
            errors++;
            $display("FAIL R7 ratio-one span: actual %0d expected 17", span);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule